// File: doc/BRIEF.md
# Electrical Idle Event Monitor

This block watches one direction of a serial link's receive path, one decoded 8-bit symbol at a time, alongside a level input that reports electrical idle on the line. It follows each power-saving episode from start to finish. First it recognizes the idle ordered set that announces the line going quiet. It then fires a trigger when electrical idle begins and times how long the quiet period lasts. When the line wakes up, it counts the fast training ordered sets that follow. It flags electrical idle that arrives without the announcing ordered set as a protocol error.

The block also drives a capture-enable qualifier for a trace recorder placed downstream. Two configuration bits can drop idle-related or fast-training-related symbols from the capture. Start-of-set comma symbols are always kept, so the recorded trace still shows where each set began. Symbol encodings used: comma is K-symbol 0xBC, idle is K-symbol 0x7C, fast training is K-symbol 0x3C.

Top module: `elecIdleMonitor`

## Requirements
- R1: An idle ordered set is a comma (symIsK=1, 0xBC) followed by three idle symbols (symIsK=1, 0x7C), counted over valid symbols only. Completing one arms the monitor, and electrical idle that begins while armed is not flagged as an error.
- R2: A symbol that breaks a partial ordered set discards the partial match. If the breaking symbol is a comma, a new set starts at that symbol.
- R3: trigPulse is high for exactly one cycle, in the cycle after eiDetect is first sampled high, and only when trigEn was high at that sample.
- R4: protoErr pulses, with the same timing as trigPulse, when electrical idle begins without the monitor being armed. While armed, a valid symbol other than a comma or an idle K-symbol disarms the monitor.
- R5: The duration equals the number of consecutive cycles in which eiDetect was sampled high. It saturates at all ones. It appears on eiDuration, together with a one-cycle durDone, in the cycle after eiDetect is first sampled low.
- R6: ftsCount clears when electrical idle ends. It then counts each complete fast training set (comma followed by three 0x3C K-symbols). A broken set is not counted and does not stop counting.
- R7: After at least one fast training set has been counted, the first valid symbol that is neither a comma nor a 0x3C K-symbol raises ftsDone for one cycle. From then on ftsCount holds its final value.
- R8: captureEn is registered and applies to the symbol sampled one cycle earlier. It is 0 when that symbol was not valid and 1 for a valid symbol that no filter drops.
- R9: With dropIdle=1, idle K-symbols and symbols that arrive while eiDetect is high are not captured. Commas and data symbols are still captured.
- R10: With dropFts=1, fast training K-symbols (0x3C) are not captured. With dropFts=0, they are captured.
- R11: While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| symData | input | 8 | Decoded symbol value |
| symIsK | input | 1 | Symbol is a control (K) symbol |
| symValid | input | 1 | Symbol strobe |
| eiDetect | input | 1 | Line is in electrical idle (level) |
| trigEn | input | 1 | Enables the trigger for this direction |
| dropIdle | input | 1 | Filter idle symbols and electrical idle from capture |
| dropFts | input | 1 | Filter fast training symbols from capture |
| trigPulse | output | 1 | One-cycle pulse when electrical idle begins |
| protoErr | output | 1 | One-cycle pulse when electrical idle begins without an idle set |
| eiDuration | output | 32 | Last electrical idle duration in clock cycles |
| durDone | output | 1 | One-cycle pulse when eiDuration is updated |
| ftsCount | output | 16 | Fast training sets counted on the current or last exit |
| ftsDone | output | 1 | One-cycle pulse when the exit count is final |
| captureEn | output | 1 | Capture qualifier for the previous cycle's symbol |

## Verification
Every result is due one register stage after the input that causes it. trigPulse and protoErr follow the first high eiDetect sample. durDone and eiDuration follow the first low sample. ftsCount follows the fourth symbol of a set, and ftsDone follows the terminating symbol. captureEn follows the symbol it qualifies. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each check falls in the one cycle where the registered result of that particular input is visible, and one-cycle pulses are caught exactly there.

// File: rtl/eim_pkg.sv
package eim_pkg;
  localparam logic [7:0] SYM_COM = 8'hBC;
  localparam logic [7:0] SYM_IDL = 8'h7C;
  localparam logic [7:0] SYM_FTS = 8'h3C;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ARMED  = 2'd1,
    ST_EIDLE  = 2'd2,
    ST_EXIT   = 2'd3
  } monState_t;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_IDL  = 2'd1,
    KIND_FTS  = 2'd2
  } setKind_t;

  typedef struct packed {
    logic eiStart;
    logic eiRun;
    logic eiEnd;
    logic ftsInc;
  } eimStrobes_t;
endpackage

// File: rtl/eimCtrl.sv
module eimCtrl
  import eim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  symData,
  input  logic        symIsK,
  input  logic        symValid,
  input  logic        eiDetect,
  input  logic        trigEn,
  output eimStrobes_t strobes,
  output logic        trigPulse,
  output logic        protoErr,
  output logic        ftsDone
);
  monState_t state, stateNext;
  setKind_t  osKind, osKindNext;
  logic [1:0] osPos, osPosNext;
  logic seenFts, seenFtsNext;
  logic isCom, isIdl, isFts;
  logic idleSetDone, ftsSetDone, kindMatch;
  logic trigNext, errNext, ftsDoneNext;

  assign isCom = symValid && symIsK && (symData == SYM_COM);
  assign isIdl = symValid && symIsK && (symData == SYM_IDL);
  assign isFts = symValid && symIsK && (symData == SYM_FTS);
  assign kindMatch = (osKind == KIND_IDL && isIdl) || (osKind == KIND_FTS && isFts);
  assign idleSetDone = (osPos == 2'd3) && (osKind == KIND_IDL) && isIdl;
  assign ftsSetDone  = (osPos == 2'd3) && (osKind == KIND_FTS) && isFts;

  // Ordered set matcher: position counts symbols matched after the comma.
  always_comb begin
    osPosNext  = osPos;
    osKindNext = osKind;
    if (state == ST_EIDLE || eiDetect) begin
      osPosNext  = 2'd0;
      osKindNext = KIND_NONE;
    end else if (symValid) begin
      if (isCom) begin
        osPosNext  = 2'd1;
        osKindNext = KIND_NONE;
      end else if (osPos == 2'd1 && (isIdl || isFts)) begin
        osPosNext  = 2'd2;
        osKindNext = isIdl ? KIND_IDL : KIND_FTS;
      end else if (osPos == 2'd2 && kindMatch) begin
        osPosNext = 2'd3;
      end else begin
        osPosNext  = 2'd0;
        osKindNext = KIND_NONE;
      end
    end
  end

  always_comb begin
    stateNext   = state;
    seenFtsNext = seenFts;
    strobes     = '0;
    trigNext    = 1'b0;
    errNext     = 1'b0;
    ftsDoneNext = 1'b0;
    case (state)
      ST_EIDLE: begin
        if (eiDetect) begin
          strobes.eiRun = 1'b1;
        end else begin
          strobes.eiEnd = 1'b1;
          seenFtsNext   = 1'b0;
          stateNext     = ST_EXIT;
        end
      end
      default: begin
        if (eiDetect) begin
          strobes.eiStart = 1'b1;
          trigNext        = trigEn;
          errNext         = (state != ST_ARMED);
          stateNext       = ST_EIDLE;
        end else begin
          case (state)
            ST_ACTIVE: if (idleSetDone) stateNext = ST_ARMED;
            ST_ARMED:  if (symValid && !isCom && !isIdl) stateNext = ST_ACTIVE;
            ST_EXIT: begin
              if (ftsSetDone) begin
                strobes.ftsInc = 1'b1;
                seenFtsNext    = 1'b1;
              end else if (symValid && !isCom && !isFts && seenFts) begin
                ftsDoneNext = 1'b1;
                stateNext   = ST_ACTIVE;
              end
            end
            default: stateNext = state;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_ACTIVE;
      osPos     <= 2'd0;
      osKind    <= KIND_NONE;
      seenFts   <= 1'b0;
      trigPulse <= 1'b0;
      protoErr  <= 1'b0;
      ftsDone   <= 1'b0;
    end else begin
      state     <= stateNext;
      osPos     <= osPosNext;
      osKind    <= osKindNext;
      seenFts   <= seenFtsNext;
      trigPulse <= trigNext;
      protoErr  <= errNext;
      ftsDone   <= ftsDoneNext;
    end
  end
endmodule

// File: rtl/eimDatapath.sv
module eimDatapath
  import eim_pkg::*;
#(
  parameter int DUR_W = 32,
  parameter int FTS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  eimStrobes_t      strobes,
  input  logic [7:0]       symData,
  input  logic             symIsK,
  input  logic             symValid,
  input  logic             eiDetect,
  input  logic             dropIdle,
  input  logic             dropFts,
  output logic [DUR_W-1:0] eiDuration,
  output logic             durDone,
  output logic [FTS_W-1:0] ftsCount,
  output logic             captureEn
);
  localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};
  localparam logic [FTS_W-1:0] FTS_MAX = {FTS_W{1'b1}};

  logic [DUR_W-1:0] durCnt;
  logic idlSym, ftsSym, keepSym;

  assign idlSym  = symIsK && (symData == SYM_IDL);
  assign ftsSym  = symIsK && (symData == SYM_FTS);
  assign keepSym = symValid
                   && !(dropIdle && (idlSym || eiDetect))
                   && !(dropFts && ftsSym);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      durCnt     <= '0;
      eiDuration <= '0;
      durDone    <= 1'b0;
      ftsCount   <= '0;
      captureEn  <= 1'b0;
    end else begin
      durDone   <= 1'b0;
      captureEn <= keepSym;
      if (strobes.eiStart) begin
        durCnt <= {{(DUR_W-1){1'b0}}, 1'b1};
      end else if (strobes.eiRun && durCnt != DUR_MAX) begin
        durCnt <= durCnt + 1'b1;
      end
      if (strobes.eiEnd) begin
        eiDuration <= durCnt;
        durDone    <= 1'b1;
        ftsCount   <= '0;
      end else if (strobes.ftsInc && ftsCount != FTS_MAX) begin
        ftsCount <= ftsCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/elecIdleMonitor.sv
module elecIdleMonitor
  import eim_pkg::*;
#(
  parameter int DUR_W = 32,
  parameter int FTS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       symData,
  input  logic             symIsK,
  input  logic             symValid,
  input  logic             eiDetect,
  input  logic             trigEn,
  input  logic             dropIdle,
  input  logic             dropFts,
  output logic             trigPulse,
  output logic             protoErr,
  output logic [DUR_W-1:0] eiDuration,
  output logic             durDone,
  output logic [FTS_W-1:0] ftsCount,
  output logic             ftsDone,
  output logic             captureEn
);
  eimStrobes_t strobes;

  eimCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .symData(symData), .symIsK(symIsK),
    .symValid(symValid), .eiDetect(eiDetect), .trigEn(trigEn),
    .strobes(strobes), .trigPulse(trigPulse), .protoErr(protoErr),
    .ftsDone(ftsDone)
  );

  eimDatapath #(.DUR_W(DUR_W), .FTS_W(FTS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .symData(symData),
    .symIsK(symIsK), .symValid(symValid), .eiDetect(eiDetect),
    .dropIdle(dropIdle), .dropFts(dropFts), .eiDuration(eiDuration),
    .durDone(durDone), .ftsCount(ftsCount), .captureEn(captureEn)
  );
endmodule

// File: rtl/eimChecker.sv
module eimChecker #(
  parameter int DUR_W = 32,
  parameter int FTS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       symData,
  input logic             symIsK,
  input logic             symValid,
  input logic             eiDetect,
  input logic             trigEn,
  input logic             dropFts,
  input logic             trigPulse,
  input logic             protoErr,
  input logic [DUR_W-1:0] eiDuration,
  input logic             durDone,
  input logic [FTS_W-1:0] ftsCount,
  input logic             ftsDone,
  input logic             captureEn
);
  p_trig_needs_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> ($past(trigEn) && $past(eiDetect)));

  p_trig_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  p_err_on_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(eiDetect));

  p_done_after_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    durDone |-> (!$past(eiDetect) && eiDuration != '0));

  p_fts_final_r7: assert property (@(posedge clk) disable iff (!rstN)
    ftsDone |-> ftsCount != '0);

  p_fts_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ftsDone |=> $stable(ftsCount));

  p_cap_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |-> $past(symValid));

  p_cap_fts_r10: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |-> !($past(dropFts) && $past(symIsK) && $past(symData) == 8'h3C));
endmodule

bind elecIdleMonitor eimChecker #(.DUR_W(DUR_W), .FTS_W(FTS_W)) u_chk (
  .clk(clk), .rstN(rstN), .symData(symData), .symIsK(symIsK),
  .symValid(symValid), .eiDetect(eiDetect), .trigEn(trigEn),
  .dropFts(dropFts), .trigPulse(trigPulse), .protoErr(protoErr),
  .eiDuration(eiDuration), .durDone(durDone), .ftsCount(ftsCount),
  .ftsDone(ftsDone), .captureEn(captureEn)
);

// File: tb/elecIdleMonitor_test.sv
module elecIdleMonitor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] symData = 8'h00;
  logic symIsK = 1'b0, symValid = 1'b0, eiDetect = 1'b0;
  logic trigEn = 1'b1, dropIdle = 1'b0, dropFts = 1'b0;
  logic trigPulse, protoErr, durDone, ftsDone, captureEn;
  logic [31:0] eiDuration;
  logic [15:0] ftsCount;
  int nChecks = 0, nFail = 0;

  localparam int NV = 6;
  localparam int V_PRE [NV] = '{1, 1, 0, 1, 1, 0};
  localparam int V_LEN [NV] = '{5, 1, 7, 20, 3, 2};
  localparam int V_FTS [NV] = '{3, 1, 4, 5, 8, 2};
  localparam int V_BAD [NV] = '{0, 0, 0, 1, 1, 1};

  always #4 clk = ~clk;

  elecIdleMonitor uut (
    .clk(clk), .rstN(rstN), .symData(symData), .symIsK(symIsK),
    .symValid(symValid), .eiDetect(eiDetect), .trigEn(trigEn),
    .dropIdle(dropIdle), .dropFts(dropFts), .trigPulse(trigPulse),
    .protoErr(protoErr), .eiDuration(eiDuration), .durDone(durDone),
    .ftsCount(ftsCount), .ftsDone(ftsDone), .captureEn(captureEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply inputs for one cycle; on return the registered results are visible.
  task automatic tick(input logic v, input logic k, input logic [7:0] d, input logic ei);
    symValid = v; symIsK = k; symData = d; eiDetect = ei;
    @(negedge clk);
  endtask

  task automatic sendSet(input logic [7:0] kind);
    tick(1, 1, 8'hBC, 0);
    for (int i = 0; i < 3; i++) tick(1, 1, kind, 0);
  endtask

  task automatic runEvent(input string tag, input logic expErr, input int len,
                          input int nfts, input bit bad, input logic expTrig);
    tick(0, 0, 8'h00, 1);
    chk({tag, " R3 trigPulse"}, trigPulse, expTrig);
    chk({tag, " R4 protoErr"}, protoErr, expErr);
    for (int i = 1; i < len; i++) tick(0, 0, 8'h00, 1);
    if (len > 1) chk({tag, " R3 no repeat"}, trigPulse, 0);
    tick(0, 0, 8'h00, 0);
    chk({tag, " R5 durDone"}, durDone, 1);
    chk({tag, " R5 eiDuration"}, eiDuration, len);
    chk({tag, " R6 cleared"}, ftsCount, 0);
    if (bad) begin
      tick(1, 1, 8'hBC, 0); tick(1, 1, 8'h3C, 0); tick(1, 0, 8'h55, 0);
      chk({tag, " R6 broken set ignored"}, ftsCount, 0);
    end
    for (int i = 0; i < nfts; i++) sendSet(8'h3C);
    chk({tag, " R6 ftsCount"}, ftsCount, nfts);
    chk({tag, " R7 not yet done"}, ftsDone, 0);
    tick(1, 0, 8'h00, 0);
    chk({tag, " R7 ftsDone"}, ftsDone, 1);
    chk({tag, " R7 final count"}, ftsCount, nfts);
    tick(1, 0, 8'h00, 0);
    chk({tag, " R7 count holds"}, ftsCount, nfts);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11 trigPulse", trigPulse, 0);
    chk("R11 protoErr", protoErr, 0);
    chk("R11 durDone", durDone, 0);
    chk("R11 ftsCount", ftsCount, 0);
    chk("R11 captureEn", captureEn, 0);
    chk("R11 eiDuration", eiDuration, 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      tick(1, 0, 8'h00, 0); tick(1, 0, 8'h11, 0);
      if (V_PRE[v] != 0) sendSet(8'h7C);
      runEvent($sformatf("vec%0d R1", v), V_PRE[v] == 0, V_LEN[v], V_FTS[v], V_BAD[v] != 0, 1);
    end

    // R3: trigger disabled, duration still measured
    trigEn = 0;
    sendSet(8'h7C);
    runEvent("trig off R3", 0, 4, 2, 0, 0);
    trigEn = 1;

    // R2: a comma breaking a partial set starts a new one
    tick(1, 1, 8'hBC, 0); tick(1, 1, 8'h7C, 0);
    sendSet(8'h7C);
    runEvent("restart R2", 0, 2, 1, 0, 1);

    // R2: partial set broken by data does not arm
    tick(1, 1, 8'hBC, 0); tick(1, 1, 8'h7C, 0); tick(1, 1, 8'h7C, 0); tick(1, 0, 8'h00, 0);
    runEvent("partial R2", 1, 2, 1, 0, 1);

    // R4: data after a full idle set disarms
    sendSet(8'h7C);
    tick(1, 0, 8'h12, 0);
    runEvent("disarm R4", 1, 3, 1, 0, 1);

    // R8-R10: capture filtering
    tick(0, 0, 8'h00, 0);
    chk("R8 invalid not captured", captureEn, 0);
    tick(1, 0, 8'h00, 0);
    chk("R8 data captured", captureEn, 1);
    tick(1, 1, 8'h7C, 0);
    chk("R9 idle captured when unfiltered", captureEn, 1);
    dropIdle = 1;
    tick(1, 1, 8'h7C, 0);
    chk("R9 idle dropped", captureEn, 0);
    tick(1, 1, 8'hBC, 0);
    chk("R9 comma kept", captureEn, 1);
    tick(1, 1, 8'h3C, 0);
    chk("R10 fts kept without dropFts", captureEn, 1);
    dropFts = 1;
    tick(1, 1, 8'h3C, 0);
    chk("R10 fts dropped", captureEn, 0);
    tick(1, 0, 8'h3C, 0);
    chk("R10 data 0x3C kept", captureEn, 1);
    tick(1, 0, 8'h00, 1);
    chk("R9 symbol in electrical idle dropped", captureEn, 0);
    tick(0, 0, 8'h00, 0);
    chk("R5 short event duration", eiDuration, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule